// File: doc/BRIEF.md
# Iterative Shift-Rotate Unit for a Two-Register Datapath

This block moves the bits of a 36-bit accumulator, a 36-bit in-out register, or both registers joined into a single 72-bit ring. A 9-bit operation code chooses three things: the target, the direction, and whether the operation is a rotate or an arithmetic shift. Shifts treat the data as ones'-complement signed numbers, so each step multiplies or divides the value by two and the sign is preserved.

The block moves the data by one bit position per clock. It stays busy until the step count runs out and then raises done for one cycle.

To start an operation, the host holds `start` high for one cycle while the block is idle. In that cycle it supplies the opcode, the step count and the two register values. It reads the results from the outputs once `done` is seen. Step counts larger than the register width are legal. They only take longer, so software can use a long count as a timed delay.

Top module: `shrot_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `busy`, `done`, `ac_out` and `io_out` become zero.
- R2: Opcodes are octal 6DT with bits [8:4] = 11011. Bit 3 selects right (1) or left (0). Bit 2 selects arithmetic shift (1) or rotate (0). Bits [1:0] select the target: 1 is the accumulator, 2 is the in-out register, 3 is the pair. For example, 661 rotates the accumulator left and 677 shifts the pair right.
- R3: A single-register rotate moves that register circularly by one position per step and leaves the other register untouched. Thirty-six rotate steps restore the original value.
- R4: A pair rotate treats {accumulator, in-out} as one 72-bit ring with the accumulator as the high half. A bit leaving one register enters the other.
- R5: A single-register arithmetic shift keeps bit 35 (the sign). A right shift copies the sign into bit 34. A left shift fills bit 0 with the sign and discards bit 34.
- R6: A pair shift applies the same arithmetic rule to the 72-bit value. Accumulator bit 35 is the sign, and the in-out register is the low-order half.
- R7: A legal start with count N ≥ 1 sets `busy` from the next cycle for N cycles. `done` pulses for exactly one cycle in the cycle after the last step. `busy` and `done` are never high together. Counts above 36 are legal.
- R8: A start with count 0 pulses `done` in the next cycle without going busy. The outputs then equal the loaded values.
- R9: A start with an opcode outside R2 behaves like a count of 0. The loaded values pass through unchanged.
- R10: A `start` seen while `busy` is high is ignored. The running operation finishes with its own data and timing.
- R11: While idle with `start` low, `ac_out` and `io_out` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (taken only while idle) |
| opcode | input | 9 | Operation code, encoded as in R2 |
| count | input | CNT_W (7) | Number of one-position steps |
| ac_in | input | W (36) | Accumulator value loaded at start |
| io_in | input | W (36) | In-out register value loaded at start |
| busy | output | 1 | Steps remain |
| done | output | 1 | One-cycle completion pulse |
| ac_out | output | W (36) | Accumulator result |
| io_out | output | W (36) | In-out register result |

## Verification
The assertions take for granted that `rst_n` is held low for at least one edge before any traffic. They also assume that the decoded operation captured at start stays fixed while the counter runs. The properties on sign retention and on the untouched register rely on the opcode being legal whenever `busy` rises. The stimulus keeps to this by drawing opcodes mostly from the twelve legal codes, with a few deliberately illegal ones that never start a busy phase. Inputs change only on falling edges, and `start` is driven high during a busy phase only in the directed R10 case.

// File: rtl/shrot_pkg.sv
// Shared types for the shift-rotate unit: opcode width and decoded-operation record.
package shrot_pkg;
    localparam int unsigned OP_W = 9;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_AC   = 2'd1,
        TGT_IO   = 2'd2,
        TGT_PAIR = 2'd3
    } tgt_e;

    typedef struct packed {
        logic legal;
        tgt_e tgt;
        logic right;
        logic arith;
    } op_dec_t;
endpackage

// File: rtl/shrot_decode.sv
// Decodes the 9-bit operation code into target, direction and shift/rotate.
// Assumes octal 6DT encoding: [8:4]=11011, [3]=right, [2]=arith, [1:0]=target.
module shrot_decode
    import shrot_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output op_dec_t         dec
);
    // Purpose: pure field split plus legality check.
    always_comb begin
        dec.legal = (op[8:4] == 5'b11011) && (op[1:0] != 2'b00);
        dec.tgt   = dec.legal ? tgt_e'(op[1:0]) : TGT_NONE;
        dec.right = op[3];
        dec.arith = op[2];
    end
endmodule

// File: rtl/shrot_lane.sv
// One-position move of a W-bit word: rotate or ones'-complement arithmetic shift.
// Assumes the sign is bit W-1 and W >= 3.
module shrot_lane #(
    parameter int unsigned W = 36
) (
    input  logic [W-1:0] d,
    input  logic         right,
    input  logic         arith,
    output logic [W-1:0] q
);
    // Purpose: select one of the four single-step results.
    always_comb begin
        unique case ({arith, right})
            2'b00:   q = {d[W-2:0], d[W-1]};
            2'b01:   q = {d[0], d[W-1:1]};
            2'b10:   q = {d[W-1], d[W-3:0], d[W-1]};
            default: q = {d[W-1], d[W-1], d[W-2:1]};
        endcase
    end
endmodule

// File: rtl/shrot_count.sv
// Step counter: holds busy for the programmed number of steps, then pulses done.
// Assumes load is only asserted while idle; go=0 means finish without steps.
module shrot_count #(
    parameter int unsigned CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             go,
    input  logic [CNT_W-1:0] cnt,
    output logic             busy,
    output logic             done
);
    logic [CNT_W-1:0] rem_q;

    // Purpose: load, count down and signal completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            rem_q <= '0;
        end else begin
            done <= 1'b0;
            if (busy) begin
                rem_q <= rem_q - 1'b1;
                if (rem_q == CNT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end else if (load) begin
                if (go) begin
                    busy  <= 1'b1;
                    rem_q <= cnt;
                end else begin
                    done <= 1'b1;
                end
            end
        end
    end

    a_r7_last_step: assert property (@(posedge clk) disable iff (!rst_n)
        busy && rem_q == CNT_W'(1) |=> !busy && done);
    a_r7_mutex: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    a_r8_zero_done: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && load && !go |=> done && !busy);
endmodule

// File: rtl/shrot_unit.sv
// Iterative shift-rotate unit over an accumulator, an in-out register, or both
// as one 72-bit ring. One position per clock; start is taken only while idle.
// Assumes synchronous active-low reset applied before use.
module shrot_unit
    import shrot_pkg::*;
#(
    parameter int unsigned W     = 36,
    parameter int unsigned CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [OP_W-1:0]  opcode,
    input  logic [CNT_W-1:0] count,
    input  logic [W-1:0]     ac_in,
    input  logic [W-1:0]     io_in,
    output logic             busy,
    output logic             done,
    output logic [W-1:0]     ac_out,
    output logic [W-1:0]     io_out
);
    localparam int unsigned PW = 2 * W;

    op_dec_t        dec, dec_q;
    logic [W-1:0]   ac_q, io_q;
    logic           load;
    logic [W-1:0]   one_in  [2];
    logic [W-1:0]   one_out [2];
    logic [PW-1:0]  pair_out;

    assign load = start && !busy;

    shrot_decode u_dec (.op(opcode), .dec(dec));

    shrot_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load),
        .go(dec.legal && (count != '0)), .cnt(count),
        .busy(busy), .done(done)
    );

    assign one_in[0] = ac_q;
    assign one_in[1] = io_q;

    // Purpose: one single-width lane per register.
    for (genvar g = 0; g < 2; g++) begin : g_lane
        shrot_lane #(.W(W)) u_lane (
            .d(one_in[g]), .right(dec_q.right), .arith(dec_q.arith), .q(one_out[g])
        );
    end

    shrot_lane #(.W(PW)) u_pair (
        .d({ac_q, io_q}), .right(dec_q.right), .arith(dec_q.arith), .q(pair_out)
    );

    // Purpose: capture operands at start, then apply one step per busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac_q  <= '0;
            io_q  <= '0;
            dec_q <= '0;
        end else if (load) begin
            ac_q  <= ac_in;
            io_q  <= io_in;
            dec_q <= dec;
        end else if (busy) begin
            unique case (dec_q.tgt)
                TGT_AC:   ac_q <= one_out[0];
                TGT_IO:   io_q <= one_out[1];
                TGT_PAIR: {ac_q, io_q} <= pair_out;
                default:  ;
            endcase
        end
    end

    assign ac_out = ac_q;
    assign io_out = io_q;

    a_r3_other_stable: assert property (@(posedge clk) disable iff (!rst_n)
        busy && dec_q.tgt == TGT_AC |=> $stable(io_q));
    a_r3_rot_popcount: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !dec_q.arith && dec_q.tgt == TGT_IO |=> $countones(io_q) == $countones($past(io_q)));
    a_r5_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
        busy && dec_q.arith && dec_q.tgt != TGT_IO |=> ac_q[W-1] == $past(ac_q[W-1]));
    a_r10_op_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(dec_q));
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> $stable(ac_q) && $stable(io_q));
endmodule

// File: tb/sim_shrot_unit.sv
module sim_shrot_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [8:0]  opcode = '0;
    logic [6:0]  count = '0;
    logic [35:0] ac_in = '0, io_in = '0;
    logic        busy, done;
    logic [35:0] ac_out, io_out;
    int          checks = 0, fails = 0, cyc = 0;

    always #4 clk = ~clk;

    shrot_unit u0 (.clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .count(count),
                   .ac_in(ac_in), .io_in(io_in), .busy(busy), .done(done),
                   .ac_out(ac_out), .io_out(io_out));

    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog expired: got %0d cycles, expected < 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    function automatic bit legal_op(logic [8:0] op);
        return op[8:4] == 5'b11011 && op[1:0] != 2'b00;
    endfunction

    function automatic logic [71:0] step_w(logic [71:0] v, int w, bit right, bit arith);
        logic [71:0] r = '0;
        logic sgn = v[w-1];
        if (right) begin
            for (int i = 0; i < w - 1; i++) r[i] = v[i+1];
            r[w-1] = arith ? sgn : v[0];
        end else begin
            for (int i = 1; i < w; i++) r[i] = v[i-1];
            r[0] = arith ? sgn : v[w-1];
            if (arith) r[w-1] = sgn;
        end
        return r;
    endfunction

    function automatic logic [71:0] ref_run(logic [8:0] op, int n, logic [35:0] a, logic [35:0] b);
        logic [71:0] t;
        if (!legal_op(op)) return {a, b};
        for (int k = 0; k < n; k++) begin
            case (op[1:0])
                2'd1: begin t = step_w({36'd0, a}, 36, op[3], op[2]); a = t[35:0]; end
                2'd2: begin t = step_w({36'd0, b}, 36, op[3], op[2]); b = t[35:0]; end
                default: begin t = step_w({a, b}, 72, op[3], op[2]); a = t[71:36]; b = t[35:0]; end
            endcase
        end
        return {a, b};
    endfunction

    function automatic string tag_of(logic [8:0] op, int n);
        if (!legal_op(op)) return "R9";
        if (n == 0) return "R8";
        if (op[1:0] == 2'd3) return op[2] ? "R2 R6" : "R2 R4";
        return op[2] ? "R2 R5" : "R2 R3";
    endfunction

    task automatic chk(bit ok, string tag, string what, logic [71:0] got, logic [71:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // Run one operation; if intrude, pulse start with other data while busy (R10).
    task automatic run_op(logic [8:0] op, int n, logic [35:0] a, logic [35:0] b, bit intrude);
        logic [71:0] exp = ref_run(op, n, a, b);
        int lat_exp = (legal_op(op) && n > 0) ? n + 1 : 1;
        int lat = 0;
        string tg = tag_of(op, n);
        @(negedge clk);
        start = 1'b1; opcode = op; count = 7'(n); ac_in = a; io_in = b;
        @(negedge clk);
        start = 1'b0; ac_in = ~a; io_in = ~b;
        lat = 1;
        if (lat_exp > 1) chk(busy === 1'b1, "R7", "busy after start", {71'd0, busy}, 72'd1);
        while (!done && lat < 300) begin
            if (intrude && lat == 2) begin
                start = 1'b1; opcode = 9'o673; count = 7'd1;
            end else start = 1'b0;
            @(negedge clk);
            lat++;
            chk(!(busy && done), "R7", "busy with done", {70'd0, busy, done}, 72'd0);
        end
        start = 1'b0;
        chk(lat == lat_exp, intrude ? "R10 R7" : "R7", "done latency", 72'(lat), 72'(lat_exp));
        chk({ac_out, io_out} === exp, intrude ? "R10" : tg, "result", {ac_out, io_out}, exp);
        @(negedge clk);
        chk(done === 1'b0, "R7", "done single pulse", {71'd0, done}, 72'd0);
        chk({ac_out, io_out} === exp, "R11", "idle hold", {ac_out, io_out}, exp);
    endtask

    localparam logic [8:0] OPS [12] = '{9'o661, 9'o671, 9'o662, 9'o672, 9'o663, 9'o673,
                                        9'o665, 9'o675, 9'o666, 9'o676, 9'o667, 9'o677};

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && ac_out === '0 && io_out === '0, "R1", "reset state",
            {ac_out, io_out}, 72'd0);
        rst_n = 1'b1;
        // Directed corner cases.
        run_op(9'o661, 36, 36'o123456701234, 36'o777000111222, 1'b0); // R3 full circle
        run_op(9'o672, 5, 36'o1, 36'o400000000003, 1'b0);             // R3
        run_op(9'o663, 1, 36'o400000000000, 36'o000000000001, 1'b0);  // R4 bit crosses
        run_op(9'o673, 1, 36'o000000000001, 36'o000000000000, 1'b0);  // R4 bit crosses
        run_op(9'o665, 3, 36'o600000000004, 36'o5, 1'b0);             // R5 negative left
        run_op(9'o675, 4, 36'o400000000000, 36'o5, 1'b0);             // R5 sign copy
        run_op(9'o667, 2, 36'o200000000000, 36'o400000000001, 1'b0);  // R6
        run_op(9'o677, 40, 36'o700000000000, 36'o12345, 1'b0);        // R6 beyond width
        run_op(9'o671, 100, 36'o1234567, 36'o7654321, 1'b0);          // R7 long count
        run_op(9'o666, 0, 36'o111, 36'o222, 1'b0);                    // R8
        run_op(9'o664, 9, 36'o333, 36'o444, 1'b0);                    // R9 target 0
        run_op(9'o761, 9, 36'o555, 36'o666, 1'b0);                    // R9 bad group
        run_op(9'o662, 10, 36'o17, 36'o400000000071, 1'b1);           // R10
        // Constrained random.
        for (int i = 0; i < 250; i++) begin
            logic [8:0] op = ($urandom % 16 == 0) ? 9'($urandom) : OPS[$urandom % 12];
            int n = ($urandom % 8 == 0) ? 0 : int'($urandom % 80);
            run_op(op, n, {4'($urandom), 32'($urandom)}, {4'($urandom), 32'($urandom)}, 1'b0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule